// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside a processor's program counter and supplies the address of the next instruction so that a block of instructions can repeat without any branch instruction in the body. When the core executes a loop-setup instruction, it presents a start strobe together with the address of the last body instruction, a pass count and a mode bit. The sequencer records the address that follows the setup instruction as the loop head. It then compares every later program counter against the recorded last address. When the two match and the loop has not finished, it returns the loop head as the next address. The loop-back costs no extra cycle, even for a body of a single instruction.

A loop ends in one of two ways. In counted mode it ends after a given number of passes, and a count of zero selects the largest number of passes the count field can express. In until mode it ends when an external condition is true at the last instruction of the body. Loop contexts are held in a small last-in first-out stack, so loops can be nested. A setup issued when the stack is full is refused and sets a sticky overflow flag. A taken branch whose target lies outside the innermost body discards that loop, and so does an explicit abort input.

Top module: `loop_seq`

## Requirements
- R1: After reset, `loop_active` and `overflow` are low. With no loop active and no branch, `next_pc` equals `pc + 1`.
- R2: A `do_start` cycle yields `next_pc = pc + 1` and records `pc + 1` as the loop head. From the following cycle `loop_active` is high.
- R3: When `pc` equals the innermost loop's last address and the loop is not finishing, `next_pc` equals the recorded head in that same cycle. This also holds for a one-instruction body, where head and last address are equal.
- R4: In counted mode (`do_until` = 0), a count of N gives exactly N passes. On the final pass, `next_pc` at the last address is `pc + 1` and the loop is discarded.
- R5: In counted mode, a count of 0 gives 2^CW passes.
- R6: In until mode (`do_until` = 1), the loop ends at the last address when `cond_in` is 1 and repeats when it is 0. `cond_in` has no effect at any other address.
- R7: Loops nest up to DEPTH levels. Only the innermost loop's last address is compared. When an inner loop ends, the enclosing loop resumes its own passes.
- R8: A `do_start` while DEPTH loops are active is not recorded and sets `overflow`. `overflow` stays high until reset.
- R9: `abort` discards the innermost loop. It has priority over a branch and over `do_start`, and a setup in the same cycle is ignored. `next_pc` is then `pc + 1`, or `branch_target` if `branch_valid` is also high.
- R10: When `branch_valid` is high, `next_pc` equals `branch_target`. If the target lies outside the innermost body (below its head or above its last address), that loop is discarded. A target inside the body keeps the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc | input | AW | Address of the instruction executing this cycle |
| do_start | input | 1 | Loop-setup instruction executes this cycle |
| do_end | input | AW | Address of the last body instruction |
| do_count | input | CW | Number of passes, where 0 means 2^CW (counted mode) |
| do_until | input | 1 | 1: end on condition, 0: end on count |
| cond_in | input | 1 | Termination condition for until mode |
| branch_valid | input | 1 | A taken branch executes this cycle |
| branch_target | input | AW | Target of the taken branch |
| abort | input | 1 | Discard the innermost loop |
| next_pc | output | AW | Address of the next instruction |
| loop_active | output | 1 | At least one loop is recorded |
| overflow | output | 1 | Sticky: a setup was refused on a full stack |

## Verification
The bench builds the block with an 8-bit address, a 4-bit count and a stack depth of 4. With a 4-bit count, a count of zero means 16 passes, which keeps the wrap-to-maximum case short enough to run through pass by pass. With a depth of 4, the refused fifth setup can be reached, and a lost or wrongly recorded entry shows up in the address returned at the fourth loop's last instruction and in how many aborts it takes to empty the stack. The small address space also lets nested bodies, branches out of a body and the one-instruction body sit at distinct, easily predicted addresses.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

   typedef enum logic {
      MODE_COUNT = 1'b0,
      MODE_UNTIL = 1'b1
   } loop_mode_e;

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_DEC  = 2'd3
   } stk_op_e;

endpackage

// File: rtl/loop_stack.sv
module loop_stack
   import loop_seq_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 8,
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   input  logic [AW-1:0] push_head,
   input  logic [AW-1:0] push_last,
   input  logic [CW-1:0] push_count,
   input  loop_mode_e    push_mode,
   output logic [AW-1:0] top_head,
   output logic [AW-1:0] top_last,
   output logic [CW-1:0] top_count,
   output loop_mode_e    top_mode,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full
);

   logic [AW-1:0] head_a  [DEPTH];
   logic [AW-1:0] last_a  [DEPTH];
   logic [CW-1:0] count_a [DEPTH];
   loop_mode_e    mode_a  [DEPTH];

   assign empty = (level == '0);
   assign full  = (level == LW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (op == STK_PUSH && !full) begin
         level <= level + LW'(1);
      end else if (op == STK_POP && !empty) begin
         level <= level - LW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [AW-1:0] head_q;
      logic [AW-1:0] last_q;
      logic [CW-1:0] count_q;
      loop_mode_e    mode_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            head_q  <= '0;
            last_q  <= '0;
            count_q <= '0;
            mode_q  <= MODE_COUNT;
         end else if (op == STK_PUSH && level == LW'(i)) begin
            head_q  <= push_head;
            last_q  <= push_last;
            count_q <= push_count;
            mode_q  <= push_mode;
         end else if (op == STK_DEC && level == LW'(i + 1)) begin
            count_q <= count_q - CW'(1);
         end
      end

      assign head_a[i]  = head_q;
      assign last_a[i]  = last_q;
      assign count_a[i] = count_q;
      assign mode_a[i]  = mode_q;
   end

   always_comb begin
      top_head  = '0;
      top_last  = '0;
      top_count = '0;
      top_mode  = MODE_COUNT;
      for (int k = 0; k < DEPTH; k++) begin
         if (level == LW'(k + 1)) begin
            top_head  = head_a[k];
            top_last  = last_a[k];
            top_count = count_a[k];
            top_mode  = mode_a[k];
         end
      end
   end

endmodule

// File: rtl/loop_match.sv
module loop_match
   import loop_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input  logic          active,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] top_head,
   input  logic [AW-1:0] top_last,
   input  logic [CW-1:0] top_count,
   input  loop_mode_e    top_mode,
   input  logic          cond_in,
   input  logic          branch_valid,
   input  logic [AW-1:0] branch_target,
   output logic          at_last,
   output logic          finishing,
   output logic          br_leaves
);

   assign at_last   = active && (pc == top_last);
   assign finishing = (top_mode == MODE_UNTIL) ? cond_in : (top_count == CW'(1));
   assign br_leaves = active && branch_valid &&
                      ((branch_target < top_head) || (branch_target > top_last));

endmodule

// File: rtl/loop_pc_sel.sv
module loop_pc_sel #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] pc,
   input  logic          branch_valid,
   input  logic [AW-1:0] branch_target,
   input  logic          take_back,
   input  logic [AW-1:0] top_head,
   output logic [AW-1:0] next_pc
);

   always_comb begin
      if (branch_valid)   next_pc = branch_target;
      else if (take_back) next_pc = top_head;
      else                next_pc = pc + AW'(1);
   end

endmodule

// File: rtl/loop_seq.sv
module loop_seq
   import loop_seq_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 8,
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] pc,
   input  logic          do_start,
   input  logic [AW-1:0] do_end,
   input  logic [CW-1:0] do_count,
   input  logic          do_until,
   input  logic          cond_in,
   input  logic          branch_valid,
   input  logic [AW-1:0] branch_target,
   input  logic          abort,
   output logic [AW-1:0] next_pc,
   output logic          loop_active,
   output logic          overflow
);

   if (AW < 2)    begin : g_bad_aw    $error("loop_seq: AW must be at least 2");    end
   if (CW < 1)    begin : g_bad_cw    $error("loop_seq: CW must be at least 1");    end
   if (DEPTH < 1) begin : g_bad_depth $error("loop_seq: DEPTH must be at least 1"); end

   stk_op_e       stk_op;
   logic [AW-1:0] top_head;
   logic [AW-1:0] top_last;
   logic [CW-1:0] top_count;
   loop_mode_e    top_mode;
   logic [LW-1:0] stk_level;
   logic          stk_empty;
   logic          stk_full;
   logic          at_last;
   logic          loop_finish;
   logic          br_leaves;
   logic          plain_cycle;
   logic          take_back;
   logic          refuse_do;

   assign loop_active = !stk_empty;
   assign plain_cycle = !abort && !branch_valid && !do_start;
   assign take_back   = plain_cycle && at_last && !loop_finish;
   assign refuse_do   = !abort && !branch_valid && do_start && stk_full;

   loop_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (stk_op),
      .push_head  (pc + AW'(1)),
      .push_last  (do_end),
      .push_count (do_count),
      .push_mode  (do_until ? MODE_UNTIL : MODE_COUNT),
      .top_head   (top_head),
      .top_last   (top_last),
      .top_count  (top_count),
      .top_mode   (top_mode),
      .level      (stk_level),
      .empty      (stk_empty),
      .full       (stk_full)
   );

   loop_match #(.AW(AW), .CW(CW)) u_match (
      .active        (loop_active),
      .pc            (pc),
      .top_head      (top_head),
      .top_last      (top_last),
      .top_count     (top_count),
      .top_mode      (top_mode),
      .cond_in       (cond_in),
      .branch_valid  (branch_valid),
      .branch_target (branch_target),
      .at_last       (at_last),
      .finishing     (loop_finish),
      .br_leaves     (br_leaves)
   );

   loop_pc_sel #(.AW(AW)) u_pc_sel (
      .pc            (pc),
      .branch_valid  (branch_valid),
      .branch_target (branch_target),
      .take_back     (take_back),
      .top_head      (top_head),
      .next_pc       (next_pc)
   );

   // One stack action per cycle: abort, then branch, then setup, then last-address match.
   always_comb begin
      stk_op = STK_HOLD;
      if (abort) begin
         if (loop_active) stk_op = STK_POP;
      end else if (branch_valid) begin
         if (br_leaves) stk_op = STK_POP;
      end else if (do_start) begin
         if (!stk_full) stk_op = STK_PUSH;
      end else if (at_last) begin
         if (loop_finish)                stk_op = STK_POP;
         else if (top_mode == MODE_COUNT) stk_op = STK_DEC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         overflow <= 1'b0;
      else if (refuse_do) overflow <= 1'b1;
   end

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
   parameter int AW    = 16,
   parameter int DEPTH = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] pc,
   input logic          do_start,
   input logic          abort,
   input logic          branch_valid,
   input logic [AW-1:0] branch_target,
   input logic [AW-1:0] next_pc,
   input logic          loop_active,
   input logic          overflow,
   input logic [LW-1:0] stk_level,
   input logic [AW-1:0] top_head,
   input logic [AW-1:0] top_last,
   input logic          loop_finish
);

   p_idle_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_active && !branch_valid) |-> next_pc == pc + AW'(1));

   p_setup_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (do_start && !abort && !branch_valid && stk_level < LW'(DEPTH)) |=> loop_active);

   p_loop_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && pc == top_last && !loop_finish && !abort && !branch_valid && !do_start)
      |-> next_pc == top_head);

   p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stk_level <= LW'(DEPTH));

   p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (do_start && !abort && !branch_valid && stk_level == LW'(DEPTH)) |=> overflow);

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   p_abort_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && loop_active) |=> stk_level == $past(stk_level) - LW'(1));

   p_branch_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      branch_valid |-> next_pc == branch_target);

endmodule

bind loop_seq loop_seq_chk #(.AW(AW), .DEPTH(DEPTH)) u_loop_seq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pc            (pc),
   .do_start      (do_start),
   .abort         (abort),
   .branch_valid  (branch_valid),
   .branch_target (branch_target),
   .next_pc       (next_pc),
   .loop_active   (loop_active),
   .overflow      (overflow),
   .stk_level     (stk_level),
   .top_head      (top_head),
   .top_last      (top_last),
   .loop_finish   (loop_finish)
);

// File: tb/test_loop_seq.sv
module test_loop_seq;

   localparam int AW = 8;
   localparam int CW = 4;
   localparam int DEPTH = 4;

   typedef struct {
      logic [AW-1:0] exp_next;
      logic          exp_act;
      logic          exp_ovf;
      string         tag;
   } exp_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] pc = '0;
   logic          do_start = 1'b0;
   logic [AW-1:0] do_end = '0;
   logic [CW-1:0] do_count = '0;
   logic          do_until = 1'b0;
   logic          cond_in = 1'b0;
   logic          branch_valid = 1'b0;
   logic [AW-1:0] branch_target = '0;
   logic          abort = 1'b0;
   logic [AW-1:0] next_pc;
   logic          loop_active;
   logic          overflow;

   exp_item_t sb_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   loop_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) i_loop_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .pc            (pc),
      .do_start      (do_start),
      .do_end        (do_end),
      .do_count      (do_count),
      .do_until      (do_until),
      .cond_in       (cond_in),
      .branch_valid  (branch_valid),
      .branch_target (branch_target),
      .abort         (abort),
      .next_pc       (next_pc),
      .loop_active   (loop_active),
      .overflow      (overflow)
   );

   // Driver: apply one cycle of stimulus and queue the expected outputs.
   task automatic cyc(input logic [AW-1:0] p, input logic d, input logic [AW-1:0] e,
                      input logic [CW-1:0] c, input logic u, input logic cd,
                      input logic bv, input logic [AW-1:0] bt, input logic ab,
                      input logic [AW-1:0] xn, input logic xa, input logic xo,
                      input string tag);
      exp_item_t it;
      @(negedge clk);
      pc = p; do_start = d; do_end = e; do_count = c; do_until = u;
      cond_in = cd; branch_valid = bv; branch_target = bt; abort = ab;
      it.exp_next = xn; it.exp_act = xa; it.exp_ovf = xo; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(input logic [AW-1:0] p, input logic [AW-1:0] xn,
                       input logic xa, input logic xo, input string tag);
      cyc(p, 0, '0, '0, 0, 0, 0, '0, 0, xn, xa, xo, tag);
   endtask

   task automatic setup(input logic [AW-1:0] p, input logic [AW-1:0] e,
                        input logic [CW-1:0] c, input logic u,
                        input logic xa, input logic xo, input string tag);
      cyc(p, 1, e, c, u, 0, 0, '0, 0, p + AW'(1), xa, xo, tag);
   endtask

   // Monitor: compare the design against the queue away from the clock edge.
   initial begin
      exp_item_t it;
      forever begin
         @(negedge clk);
         #5;
         while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (next_pc !== it.exp_next || loop_active !== it.exp_act || overflow !== it.exp_ovf) begin
               fails++;
               $display("FAIL %s: next_pc=%0d active=%0b ovf=%0b expected next_pc=%0d active=%0b ovf=%0b",
                        it.tag, next_pc, loop_active, overflow, it.exp_next, it.exp_act, it.exp_ovf);
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pc = '0; do_start = 0; abort = 0; branch_valid = 0; cond_in = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: idle after reset
      idle(8'd5, 8'd6, 0, 0, "R1 reset idle");
      idle(8'd12, 8'd13, 0, 0, "R1 no loop at any address");

      // R2 R3 R4: counted loop of 3 passes, head 11, last 12
      setup(8'd10, 8'd12, 4'd3, 0, 0, 0, "R2 setup counted");
      for (int p = 1; p <= 3; p++) begin
         idle(8'd11, 8'd12, 1, 0, "R2 body first");
         idle(8'd12, (p < 3) ? 8'd11 : 8'd13, 1, 0, (p < 3) ? "R3 loop back" : "R4 final pass exits");
      end
      idle(8'd13, 8'd14, 0, 0, "R4 popped after final pass");

      // R5 R3: count 0 means 16 passes, one-instruction body at 21
      setup(8'd20, 8'd21, 4'd0, 0, 0, 0, "R5 setup zero count");
      for (int p = 1; p <= 16; p++)
         idle(8'd21, (p < 16) ? 8'd21 : 8'd22, 1, 0, (p < 16) ? "R5 R3 single body repeat" : "R5 exit after 16");
      idle(8'd22, 8'd23, 0, 0, "R5 popped");

      // R6: until mode, head 31, last 32
      setup(8'd30, 8'd32, 4'd5, 1, 0, 0, "R6 setup until");
      cyc(8'd31, 0, '0, '0, 0, 1, 0, '0, 0, 8'd32, 1, 0, "R6 cond ignored off last");
      cyc(8'd32, 0, '0, '0, 0, 0, 0, '0, 0, 8'd31, 1, 0, "R6 cond low repeats");
      idle(8'd31, 8'd32, 1, 0, "R6 body");
      cyc(8'd32, 0, '0, '0, 0, 0, 0, '0, 0, 8'd31, 1, 0, "R6 cond low repeats again");
      idle(8'd31, 8'd32, 1, 0, "R6 body");
      cyc(8'd32, 0, '0, '0, 0, 1, 0, '0, 0, 8'd33, 1, 0, "R6 cond high exits");
      idle(8'd33, 8'd34, 0, 0, "R6 popped");

      // R7: outer 41..45 x2, inner 42..43 x2
      setup(8'd40, 8'd45, 4'd2, 0, 0, 0, "R7 outer setup");
      for (int o = 1; o <= 2; o++) begin
         setup(8'd41, 8'd43, 4'd2, 0, 1, 0, "R7 inner setup");
         idle(8'd42, 8'd43, 1, 0, "R7 inner body");
         idle(8'd43, 8'd42, 1, 0, "R7 inner loop back");
         idle(8'd42, 8'd43, 1, 0, "R7 inner body");
         idle(8'd43, 8'd44, 1, 0, "R7 inner exit");
         idle(8'd44, 8'd45, 1, 0, "R7 outer resumes");
         idle(8'd45, (o < 2) ? 8'd41 : 8'd46, 1, 0, (o < 2) ? "R7 outer loop back" : "R7 outer exit");
      end
      idle(8'd46, 8'd47, 0, 0, "R7 all popped");

      // R8 R9: fill the stack, refuse a fifth setup, then abort to empty
      setup(8'd50, 8'd90, 4'd2, 0, 0, 0, "R8 push 1");
      setup(8'd51, 8'd91, 4'd2, 0, 1, 0, "R8 push 2");
      setup(8'd52, 8'd92, 4'd2, 0, 1, 0, "R8 push 3");
      setup(8'd53, 8'd93, 4'd2, 0, 1, 0, "R8 push 4");
      setup(8'd54, 8'd94, 4'd2, 0, 1, 0, "R8 fifth setup refused");
      idle(8'd55, 8'd56, 1, 1, "R8 overflow raised");
      idle(8'd93, 8'd54, 1, 1, "R8 top is fourth entry");
      for (int a = 0; a < 4; a++)
         cyc(8'd56 + AW'(a), 0, '0, '0, 0, 0, 0, '0, 1, 8'd57 + AW'(a), 1, 1, "R9 abort pops");
      idle(8'd60, 8'd61, 0, 1, "R9 R8 empty after four aborts, overflow sticky");
      do_reset();
      idle(8'd60, 8'd61, 0, 0, "R1 R8 overflow cleared by reset");

      // R10: branch inside keeps loop, branch outside pops
      setup(8'd60, 8'd63, 4'd5, 0, 0, 0, "R10 setup");
      cyc(8'd61, 0, '0, '0, 0, 0, 1, 8'd62, 0, 8'd62, 1, 0, "R10 branch inside body");
      cyc(8'd62, 0, '0, '0, 0, 0, 1, 8'd70, 0, 8'd70, 1, 0, "R10 branch leaves body");
      idle(8'd70, 8'd71, 0, 0, "R10 loop discarded");

      // R9: abort beats a simultaneous setup
      setup(8'd80, 8'd85, 4'd3, 0, 0, 0, "R9 setup");
      cyc(8'd81, 1, 8'd99, 4'd2, 0, 0, 0, '0, 1, 8'd82, 1, 0, "R9 abort with setup");
      idle(8'd82, 8'd83, 0, 0, "R9 setup ignored, stack empty");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
   end

endmodule